// File: doc/BRIEF.md
# Stream Start-Marker Framer

The framer sits behind a byte-wide receive stream that supplies one data byte per valid strobe, such as a UART receiver. It is idle after reset and stays idle until an arm pulse. Once armed, it hunts for a four-byte start marker. Every byte that arrives during the hunt, including the marker itself, is dropped and counted. When the marker completes, the framer forwards a fixed number of payload bytes downstream and then raises a completion flag.

The marker test runs after every byte. It looks at the newest four bytes, which are held in a small circular window. The window is cleared on arm, so bytes left over from an earlier session cannot combine with new ones into a false marker.

While armed and still waiting for its first byte, the framer emits a slow heartbeat pulse whose period is a programmable number of clock cycles. It also flags whether the first four payload bytes carried the expected sync word. The downstream side cannot apply backpressure, so it must take each forwarded byte in the cycle that its strobe is high.

Top module: `marker_framer`

## Requirements
- R1: After reset the block is idle. `tx_valid_o`, `done_o`, `sync_ok_o` and `beat_o` are low and `discard_cnt_o` is zero. Bytes that arrive before the first arm pulse are neither forwarded nor counted.
- R2: An arm pulse, sampled at a rising clock edge, starts the marker hunt. After that edge `done_o` and `sync_ok_o` are low and `discard_cnt_o` is zero.
- R3: Arming clears the four-byte window, so bytes received before an arm can never count toward a marker matched after it.
- R4: The marker is the byte sequence 0xFF, 0x00, 0x00, 0xFF in arrival order. It is tested after every received byte against the newest four bytes, so a marker that overlaps a partial marker is found at its first complete occurrence.
- R5: No byte received during the hunt is forwarded, the four marker bytes included. After the hunt, `discard_cnt_o` equals the number of bytes received from the arm up to and including the last marker byte.
- R6: Each payload byte appears on `tx_data_o`, with `tx_valid_o` high for exactly one cycle, in the clock cycle after the cycle in which it was received. Payload bytes keep their arrival order.
- R7: Exactly PAYLOAD_LEN payload bytes are forwarded. `done_o` rises in the same cycle as the last forwarded byte and stays high until the next arm. Bytes received after that are neither forwarded nor counted.
- R8: `sync_ok_o` rises together with the fourth forwarded byte if the first four payload bytes were 0x7E, 0xAA, 0x99, 0x7E in that order. Otherwise it stays low until the next arm.
- R9: During the hunt, while no byte has arrived since the arm, `beat_o` pulses high for one cycle every HB_CYCLES cycles. The first pulse comes HB_CYCLES cycles after the arm edge. No pulse follows once a byte has arrived.
- R10: An arm pulse in any state, including partway through a payload, restarts the hunt and resets the payload count. A byte that arrives in the same cycle as an arm pulse is dropped.
- R11: Idle cycles of any length between received bytes do not change what is forwarded or counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arm_i | input | 1 | One-cycle pulse that starts or restarts the marker hunt |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Forwarded payload byte strobe |
| tx_data_o | output | 8 | Forwarded payload byte |
| done_o | output | 1 | All payload bytes forwarded |
| sync_ok_o | output | 1 | First four payload bytes matched the sync word |
| discard_cnt_o | output | DISC_W | Bytes dropped during the current hunt |
| beat_o | output | 1 | Heartbeat pulse while waiting for the first byte |

## Verification
The bench sweeps the length of the junk prefix and uses prefixes built from partial markers (FF 00 00 00, FF FF 00). A matcher that compares bytes in the wrong order, or that skips overlapping windows, would lock onto the wrong byte and forward a shifted payload. Separate cases check the following, each against the fault it would expose:
- A corrupted sync word at each of the four positions: a matcher that checks only some positions would still raise `sync_ok_o`.
- A stale FF 00 00 left in the window before a re-arm: a window that is not cleared would take the next FF as a marker.
- A re-arm partway through a payload: a counter that is not reset would end the next payload early.
- Bytes sent after completion: a block that keeps forwarding would overrun the downstream buffer.
- Back-to-back and gapped byte streams.
- The heartbeat spacing: a counter that is off by one, or that keeps running after data arrives, would show up here.

// File: rtl/mf_pkg.sv
package mf_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WIN_DEPTH = 4;
  localparam int unsigned WIN_PTR_W = $clog2(WIN_DEPTH);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOAD = 2'd2,
    ST_DONE = 2'd3
  } mf_state_e;

  // Start marker, oldest byte first.
  function automatic logic [BYTE_W-1:0] marker_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    marker_byte = 8'hFF;
      2'd1:    marker_byte = 8'h00;
      2'd2:    marker_byte = 8'h00;
      default: marker_byte = 8'hFF;
    endcase
  endfunction

  // Sync word that heads a well-formed payload, first byte first.
  function automatic logic [BYTE_W-1:0] sync_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    sync_byte = 8'h7E;
      2'd1:    sync_byte = 8'hAA;
      2'd2:    sync_byte = 8'h99;
      default: sync_byte = 8'h7E;
    endcase
  endfunction

endpackage

// File: rtl/mf_window.sv
module mf_window
  import mf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);

  logic [BYTE_W-1:0]    ent_q [WIN_DEPTH];
  logic [WIN_PTR_W-1:0] wr_ptr_q;
  logic [WIN_PTR_W-1:0] wr_ptr_d;
  logic                 all_eq;

  // Oldest held byte sits just after the write pointer; the incoming byte is the newest.
  always_comb begin
    all_eq = (byte_i == marker_byte(2'(WIN_DEPTH - 1)));
    for (int k = 0; k < WIN_DEPTH - 1; k++) begin
      if (ent_q[wr_ptr_q + WIN_PTR_W'(k + 1)] != marker_byte(2'(k))) begin
        all_eq = 1'b0;
      end
    end
  end

  assign hit_o = push_i & all_eq;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    if (clr_i) begin
      wr_ptr_d = '0;
    end else if (push_i) begin
      wr_ptr_d = wr_ptr_q + WIN_PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
    end
  end

  for (genvar g = 0; g < WIN_DEPTH; g++) begin : g_ent
    logic ent_we;
    assign ent_we = push_i && (wr_ptr_q == WIN_PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (clr_i) begin
        ent_q[g] <= '0;
      end else if (ent_we) begin
        ent_q[g] <= byte_i;
      end
    end
  end

endmodule

// File: rtl/mf_heartbeat.sv
module mf_heartbeat #(
  parameter int unsigned HB_CYCLES = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic active_i,
  output logic beat_o
);

  localparam int unsigned CNT_W = (HB_CYCLES > 1) ? $clog2(HB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             beat_q, beat_d;

  always_comb begin
    cnt_d  = cnt_q;
    beat_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (active_i) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        beat_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      beat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
    end
  end

  assign beat_o = beat_q;

endmodule

// File: rtl/mf_payload.sv
module mf_payload
  import mf_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 135100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              last_o,
  output logic              sync_ok_o
);

  localparam int unsigned CNT_W = $clog2(PAYLOAD_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD_LEN - 1);
  localparam logic [CNT_W-1:0] HEAD_LEN = CNT_W'(4);
  localparam logic [CNT_W-1:0] HEAD_END = CNT_W'(3);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             good_q, good_d;
  logic             ok_q, ok_d;
  logic             in_head;
  logic             byte_eq;

  assign in_head = (cnt_q < HEAD_LEN);
  assign byte_eq = (byte_i == sync_byte(cnt_q[1:0]));
  assign last_o  = take_i && (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    ok_d   = ok_q;
    if (clr_i) begin
      cnt_d  = '0;
      good_d = 1'b1;
      ok_d   = 1'b0;
    end else if (take_i) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (in_head && !byte_eq) begin
        good_d = 1'b0;
      end
      if ((cnt_q == HEAD_END) && good_q && byte_eq) begin
        ok_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b1;
      ok_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
      ok_q   <= ok_d;
    end
  end

  assign sync_ok_o = ok_q;

endmodule

// File: rtl/marker_framer.sv
module marker_framer
  import mf_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 135100,
  parameter int unsigned HB_CYCLES   = 200_000_000,
  parameter int unsigned DISC_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              done_o,
  output logic              sync_ok_o,
  output logic [DISC_W-1:0] discard_cnt_o,
  output logic              beat_o
);

  mf_state_e         state_q, state_d;
  logic              hunting, loading;
  logic              push, take, hit, last;
  logic [DISC_W-1:0] disc_q, disc_d;
  logic              tx_vld_q;
  logic [7:0]        tx_dat_q;
  logic              done_q, done_d;
  logic              beat_active;

  assign hunting = (state_q == ST_HUNT);
  assign loading = (state_q == ST_LOAD);
  assign push    = rx_valid_i && hunting && !arm_i;
  assign take    = rx_valid_i && loading && !arm_i;

  mf_window u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (arm_i),
    .push_i (push),
    .byte_i (rx_data_i),
    .hit_o  (hit)
  );

  mf_payload #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_payload (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (arm_i),
    .take_i    (take),
    .byte_i    (rx_data_i),
    .last_o    (last),
    .sync_ok_o (sync_ok_o)
  );

  assign beat_active = hunting && (disc_q == '0) && !rx_valid_i && !arm_i;

  mf_heartbeat #(.HB_CYCLES(HB_CYCLES)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (arm_i),
    .active_i (beat_active),
    .beat_o   (beat_o)
  );

  always_comb begin
    state_d = state_q;
    if (arm_i) begin
      state_d = ST_HUNT;
    end else begin
      case (state_q)
        ST_HUNT: if (hit)  state_d = ST_LOAD;
        ST_LOAD: if (last) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    disc_d = disc_q;
    done_d = done_q;
    if (arm_i) begin
      disc_d = '0;
      done_d = 1'b0;
    end else begin
      if (push) disc_d = disc_q + DISC_W'(1);
      if (last) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      disc_q   <= '0;
      done_q   <= 1'b0;
      tx_vld_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      disc_q   <= disc_d;
      done_q   <= done_d;
      tx_vld_q <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dat_q <= '0;
    end else if (take) begin
      tx_dat_q <= rx_data_i;
    end
  end

  assign tx_valid_o    = tx_vld_q;
  assign tx_data_o     = tx_dat_q;
  assign done_o        = done_q;
  assign discard_cnt_o = disc_q;

endmodule

// File: rtl/mf_checker.sv
module mf_checker #(
  parameter int unsigned DISC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_i,
  input logic              rx_valid_i,
  input logic              tx_valid_o,
  input logic              done_o,
  input logic              sync_ok_o,
  input logic [DISC_W-1:0] discard_cnt_o,
  input logic              beat_o
);

  // R6
  tx_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> ($past(rx_valid_i) && !$past(arm_i)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> done_o);

  // R7
  no_tx_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> !tx_valid_o);

  // R2
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (!done_o && !tx_valid_o && !sync_ok_o && (discard_cnt_o == '0)));

  // R9
  beat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |-> ((discard_cnt_o == '0) && !done_o && !tx_valid_o));

  // R5
  disc_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(discard_cnt_o) |-> ($past(rx_valid_i) || $past(arm_i)));

  // R8
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok_o) |-> tx_valid_o);

endmodule

bind marker_framer mf_checker #(.DISC_W(DISC_W)) u_mf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .arm_i         (arm_i),
  .rx_valid_i    (rx_valid_i),
  .tx_valid_o    (tx_valid_o),
  .done_o        (done_o),
  .sync_ok_o     (sync_ok_o),
  .discard_cnt_o (discard_cnt_o),
  .beat_o        (beat_o)
);

// File: tb/marker_framer_tb_top.sv
`timescale 1ns/1ps
module marker_framer_tb_top;

  localparam int LEN = 12;
  localparam int HB  = 5;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm;
  logic          rxv;
  logic [7:0]    rxd;
  logic          txv;
  logic [7:0]    txd;
  logic          done;
  logic          sync_ok;
  logic [DW-1:0] disc;
  logic          beat;

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [7:0] cap    [0:63];
  logic       cap_dn [0:63];

  always #2.5 clk = ~clk;

  marker_framer #(.PAYLOAD_LEN(LEN), .HB_CYCLES(HB), .DISC_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .rx_valid_i(rxv), .rx_data_i(rxd),
    .tx_valid_o(txv), .tx_data_o(txd), .done_o(done), .sync_ok_o(sync_ok),
    .discard_cnt_o(disc), .beat_o(beat)
  );

  always @(negedge clk) begin
    if (rst_n && txv) begin
      if (cap_n < 64) begin
        cap[cap_n]    = txd;
        cap_dn[cap_n] = done;
      end
      cap_n++;
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
    #1;
    cap_n = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    rxv = 1'b1;
    rxd = b;
    @(negedge clk);
    #1;
    rxv = 1'b0;
    repeat (gap) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] junk_byte(input int j);
    case (j)
      0: junk_byte = 8'hFF;
      1: junk_byte = 8'h00;
      2: junk_byte = 8'h00;
      3: junk_byte = 8'h00;
      4: junk_byte = 8'hFF;
      5: junk_byte = 8'h00;
      6: junk_byte = 8'h12;
      7: junk_byte = 8'hFF;
      8: junk_byte = 8'hFF;
      default: junk_byte = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] sync_val(input int i);
    case (i)
      0: sync_val = 8'h7E;
      1: sync_val = 8'hAA;
      2: sync_val = 8'h99;
      default: sync_val = 8'h7E;
    endcase
  endfunction

  task automatic run_session(input int junk, input int gap, input int bad, input bit trap);
    logic [7:0] tx [0:63];
    int n = 0;
    int m = -1;
    int exp_sync;
    int disc_now;
    if (trap) begin
      do_arm();
      send_byte(8'hFF, 0);
      send_byte(8'h00, 0);
      send_byte(8'h00, 0);
    end
    do_arm();
    chk_eq("R2 discard after arm", int'(disc), 0);
    chk_eq("R2 done after arm", int'(done), 0);
    chk_eq("R2 sync_ok after arm", int'(sync_ok), 0);
    if (trap) begin tx[n] = 8'hFF; n++; end
    for (int j = 0; j < junk; j++) begin tx[n] = junk_byte(j); n++; end
    tx[n] = 8'hFF; tx[n+1] = 8'h00; tx[n+2] = 8'h00; tx[n+3] = 8'hFF; n += 4;
    for (int i = 0; i < LEN; i++) begin
      tx[n] = (i < 4) ? sync_val(i) : 8'((i * 37 + 5) & 255);
      if (i == bad) tx[n] = tx[n] ^ 8'h01;
      n++;
    end
    // reference: first complete marker in arrival order (R4)
    for (int i = 3; i < n; i++) begin
      if (m < 0 && tx[i-3] == 8'hFF && tx[i-2] == 8'h00 && tx[i-1] == 8'h00 && tx[i] == 8'hFF)
        m = i;
    end
    for (int i = 0; i < n; i++) send_byte(tx[i], gap);
    settle();
    chk_eq(trap ? "R3 forwarded count" : "R7 R11 forwarded count", cap_n, LEN);
    for (int i = 0; i < LEN; i++) begin
      chk_eq("R6 R4 payload byte", int'(cap[i]), int'(tx[m + 1 + i]));
      chk_eq("R7 done with last byte", int'(cap_dn[i]), (i == LEN - 1) ? 1 : 0);
    end
    chk_eq("R5 R4 discard count", int'(disc), m + 1);
    chk_eq("R7 done", int'(done), 1);
    exp_sync = 1;
    for (int i = 0; i < 4; i++) if (tx[m + 1 + i] != sync_val(i)) exp_sync = 0;
    chk_eq("R8 sync flag", int'(sync_ok), exp_sync);
    disc_now = int'(disc);
    send_byte(8'hFF, gap);
    send_byte(8'h00, gap);
    send_byte(8'h7E, gap);
    settle();
    chk_eq("R7 bytes after done ignored", cap_n, LEN);
    chk_eq("R7 discard frozen after done", int'(disc), disc_now);
    chk_eq("R7 done held", int'(done), 1);
  endtask

  initial begin
    int beats;
    int first;
    rst_n = 1'b0;
    arm   = 1'b0;
    rxv   = 1'b0;
    rxd   = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_eq("R1 reset tx_valid", int'(txv), 0);
    chk_eq("R1 reset done", int'(done), 0);
    chk_eq("R1 reset sync_ok", int'(sync_ok), 0);
    chk_eq("R1 reset discard", int'(disc), 0);
    chk_eq("R1 reset beat", int'(beat), 0);

    // R1: bytes before any arm are ignored
    send_byte(8'hFF, 0); send_byte(8'h00, 0); send_byte(8'h00, 0); send_byte(8'hFF, 0);
    for (int i = 0; i < 4; i++) send_byte(sync_val(i), 0);
    settle();
    chk_eq("R1 idle forwards nothing", cap_n, 0);
    chk_eq("R1 idle discard", int'(disc), 0);
    chk_eq("R1 idle done", int'(done), 0);

    // R9: heartbeat spacing while no byte has arrived
    do_arm();
    beats = 0;
    first = -1;
    for (int i = 0; i < 3 * HB; i++) begin
      @(negedge clk);
      if (beat) begin
        if (first < 0) first = i;
        beats++;
      end
    end
    #1;
    chk_eq("R9 beat count", beats, 3);
    chk_eq("R9 first beat position", first, HB - 2);
    send_byte(8'h12, 0);
    beats = 0;
    for (int i = 0; i < 3 * HB; i++) begin
      @(negedge clk);
      if (beat) beats++;
    end
    #1;
    chk_eq("R9 beat stops after a byte", beats, 0);

    // R4 R5 R11: junk prefix sweep, back-to-back and gapped
    for (int g = 0; g < 2; g++)
      for (int j = 0; j <= 9; j++)
        run_session(j, g, -1, 1'b0);

    // R8: sync word corrupted at each position
    for (int b = 0; b < 4; b++) run_session(3, 0, b, 1'b0);

    // R3: stale window bytes before re-arm
    run_session(0, 0, -1, 1'b1);
    run_session(5, 1, -1, 1'b1);

    // R10: re-arm partway through a payload
    do_arm();
    send_byte(8'hFF, 0); send_byte(8'h00, 0); send_byte(8'h00, 0); send_byte(8'hFF, 0);
    for (int i = 0; i < 5; i++) send_byte(sync_val(i), 0);
    settle();
    chk_eq("R10 partial payload forwarded", cap_n, 5);
    chk_eq("R10 sync seen before re-arm", int'(sync_ok), 1);
    run_session(2, 0, -1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule